// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block gathers every reset request in the chip into a single system reset line and keeps a record of what caused each reset. Eight requests arrive as synchronous, active-high levels: power-on, brown-out, software reset, watchdog, configuration mismatch, trap conflict, illegal opcode and uninitialized working register. The external reset pin is active low and passes through a debounce filter first. While any request is present, and for a fixed stretch after the last one goes away, the system reset output stays high. It then drops on a clock edge.

An eight-bit cause register is readable and writable from the processor bus. Each bit is set by its own hardware source and stays set across every reset except power-on. Power-on loads a fixed pattern. Software may write any value at any time, and a write never starts a reset. Software normally reads the register after boot and then clears it, so the next reset leaves a clean record.

The reset sequencer is a three-state machine:
- **ST_IDLE**: the output is low.
- **ST_ACTIVE**: at least one request is present.
- **ST_STRETCH**: no request is present and the hold counter is running.

Its transitions are:
- **ST_IDLE → ST_ACTIVE** when a request appears.
- **ST_ACTIVE → ST_STRETCH** when all requests are gone.
- **ST_STRETCH → ST_ACTIVE** when a request returns. This is a re-trigger.
- **ST_STRETCH → ST_IDLE** when the hold count expires.

Power-on forces the machine into ST_ACTIVE.

Top module: `rstc_top`

## Requirements
- R1: If any of the eight direct request inputs is high at a rising clock edge, `sys_rst` is high right after that edge.
- R2: When `ext_rst_n` is sampled low at 4 consecutive rising edges, `sys_rst` goes high and cause bit 2 is set at the next edge.
- R3: A low pulse on `ext_rst_n` that spans fewer than 4 rising edges changes neither `sys_rst` nor the cause register.
- R4: The cause bits are: bit 0 power-on, bit 1 brown-out, bit 2 external pin, bit 3 software, bit 4 watchdog, bit 5 configuration mismatch, bit 6 illegal opcode or uninitialized register (shared), bit 7 trap conflict. A source that is high at an edge sets its bit at that edge.
- R5: While `por_req` is high at an edge, the cause register loads 8'h03 (all other bits clear) and `sys_rst` is held high.
- R6: Every reset other than power-on leaves the existing cause bits in place. New causes accumulate with the old ones.
- R7: When several sources are high in the same cycle, all of their cause bits are set together.
- R8: A write (`cause_wr` high) loads `cause_wdata` into the register at the next edge. A write never asserts `sys_rst`, whatever value it carries.
- R9: If a write and a hardware set hit the same bit in the same cycle, the bit ends up set.
- R10: `sys_rst` falls right after the 16th consecutive rising edge at which no request is present. The release is synchronous to `clk`.
- R11: A request that arrives during ST_STRETCH returns the sequencer to ST_ACTIVE. The 16-edge hold then restarts from that request's release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request; also initialises the block |
| bor_req | input | 1 | Brown-out request |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous to clk |
| swr_req | input | 1 | Software reset instruction request |
| wdt_req | input | 1 | Watchdog timeout request |
| cm_req | input | 1 | Configuration mismatch request |
| trap_req | input | 1 | Trap conflict request |
| iop_req | input | 1 | Illegal opcode request |
| uwr_req | input | 1 | Uninitialized working register request |
| cause_wr | input | 1 | Cause register write strobe |
| cause_wdata | input | 8 | Cause register write data |
| cause_rdata | output | 8 | Cause register contents |
| sys_rst | output | 1 | System reset, active high |

## Verification
The hardest case to reach from the ports is the re-trigger from ST_STRETCH. The hold counter is not visible, so the only evidence is the moment `sys_rst` finally falls. The stimulus releases a watchdog request, waits six cycles so that the sequencer is partway through its stretch, and pulses the software request. It then expects the fall exactly 16 edges after that second release, not after the first. A second hard case is a write and a hardware set landing in the same cycle. The bench raises the watchdog request on the very cycle it writes zero, so the bit must come back set.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int CAUSE_W   = 8;
    localparam int B_POR     = 0;
    localparam int B_BOR     = 1;
    localparam int B_PIN     = 2;
    localparam int B_SWR     = 3;
    localparam int B_WDT     = 4;
    localparam int B_CM      = 5;
    localparam int B_OPC     = 6;
    localparam int B_TRAP    = 7;
    localparam logic [CAUSE_W-1:0] POR_PATTERN = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_STRETCH = 2'd2
    } rst_state_e;
endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic init,
    input  logic pin_n,
    output logic pin_req
);
    localparam int FW = $clog2(FILT_LEN + 1);

    logic [FW-1:0] low_run;

    // consecutive-low counter, saturating at the filter length
    always_ff @(posedge clk) begin
        if (init) begin
            low_run <= '0;
        end else if (!pin_n) begin
            if (low_run != FW'(FILT_LEN))
                low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    assign pin_req = (low_run == FW'(FILT_LEN));
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic               clk,
    input  logic               init,
    input  logic [CAUSE_W-1:0] hw_set,
    input  logic               wr,
    input  logic [CAUSE_W-1:0] wdata,
    output logic [CAUSE_W-1:0] q
);
    logic [CAUSE_W-1:0] base;

    always_comb begin
        base = wr ? wdata : q;
    end

    // hardware sets are OR-ed after the write so they always win
    always_ff @(posedge clk) begin
        if (init)
            q <= POR_PATTERN;
        else
            q <= base | hw_set;
    end
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int HOLD_LEN = 16
) (
    input  logic clk,
    input  logic init,
    input  logic any_req,
    output logic rst_out
);
    localparam int CW = $clog2(HOLD_LEN);

    rst_state_e    state, nxt;
    logic [CW-1:0] hold_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (init)
            state <= ST_ACTIVE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (any_req) nxt = ST_ACTIVE;
            ST_ACTIVE:  if (!any_req) nxt = ST_STRETCH;
            ST_STRETCH: begin
                if (any_req)
                    nxt = ST_ACTIVE;
                else if (hold_cnt == CW'(HOLD_LEN - 1))
                    nxt = ST_IDLE;
            end
        endcase
    end

    // hold counter: first quiet edge counts as one
    always_ff @(posedge clk) begin
        if (init || state == ST_ACTIVE || state == ST_IDLE)
            hold_cnt <= CW'(1);
        else if (state == ST_STRETCH)
            hold_cnt <= hold_cnt + 1'b1;
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_IDLE:    rst_out = 1'b0;
            ST_ACTIVE:  rst_out = 1'b1;
            ST_STRETCH: rst_out = 1'b1;
            default:    rst_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int HOLD_LEN = 16
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               bor_req,
    input  logic               ext_rst_n,
    input  logic               swr_req,
    input  logic               wdt_req,
    input  logic               cm_req,
    input  logic               trap_req,
    input  logic               iop_req,
    input  logic               uwr_req,
    input  logic               cause_wr,
    input  logic [CAUSE_W-1:0] cause_wdata,
    output logic [CAUSE_W-1:0] cause_rdata,
    output logic               sys_rst
);
    logic               pin_req;
    logic [CAUSE_W-1:0] src_vec;
    logic               any_req;

    rstc_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .init    (por_req),
        .pin_n   (ext_rst_n),
        .pin_req (pin_req)
    );

    always_comb begin
        src_vec         = '0;
        src_vec[B_POR]  = por_req;
        src_vec[B_BOR]  = bor_req;
        src_vec[B_PIN]  = pin_req;
        src_vec[B_SWR]  = swr_req;
        src_vec[B_WDT]  = wdt_req;
        src_vec[B_CM]   = cm_req;
        src_vec[B_OPC]  = iop_req | uwr_req;
        src_vec[B_TRAP] = trap_req;
    end

    assign any_req = |src_vec;

    rstc_cause_reg u_cause (
        .clk    (clk),
        .init   (por_req),
        .hw_set (src_vec),
        .wr     (cause_wr),
        .wdata  (cause_wdata),
        .q      (cause_rdata)
    );

    rstc_seq #(.HOLD_LEN(HOLD_LEN)) u_seq (
        .clk     (clk),
        .init    (por_req),
        .any_req (any_req),
        .rst_out (sys_rst)
    );
endmodule

// File: rtl/rstc_top_chk.sv
module rstc_top_chk #(
    parameter int HOLD_LEN = 16
) (
    input logic       clk,
    input logic       por_req,
    input logic       bor_req,
    input logic       ext_rst_n,
    input logic       swr_req,
    input logic       wdt_req,
    input logic       cm_req,
    input logic       trap_req,
    input logic       iop_req,
    input logic       uwr_req,
    input logic       cause_wr,
    input logic [7:0] cause_wdata,
    input logic [7:0] cause_rdata,
    input logic       sys_rst
);
    localparam int LW = $clog2(HOLD_LEN + 1);

    logic [7:0]    dvec;
    logic          any_direct;
    logic          pin_d;
    logic          por_q;
    logic [LW-1:0] quiet_cnt;

    assign dvec = {trap_req, iop_req | uwr_req, cm_req, wdt_req, swr_req,
                   1'b0, bor_req, por_req};
    assign any_direct = |dvec;

    always_ff @(posedge clk) begin
        pin_d <= ext_rst_n;
        por_q <= por_req;
        if (por_req || any_direct)
            quiet_cnt <= '0;
        else if (quiet_cnt != LW'(HOLD_LEN))
            quiet_cnt <= quiet_cnt + 1'b1;
    end

    // R5: the edge after power-on shows the fixed pattern
    always_ff @(posedge clk) begin
        if (por_q === 1'b1)
            assert_por_load_R5: assert (cause_rdata == 8'h03 && sys_rst);
    end

    assert_src_to_rst_R1: assert property (@(posedge clk) disable iff (por_req)
        any_direct |=> sys_rst);

    assert_hw_set_R4: assert property (@(posedge clk) disable iff (por_req)
        any_direct |=> ((cause_rdata & $past(dvec)) == $past(dvec)));

    assert_keep_R6: assert property (@(posedge clk) disable iff (por_req)
        (!cause_wr && !any_direct && ext_rst_n && pin_d) |=> $stable(cause_rdata));

    assert_write_R8: assert property (@(posedge clk) disable iff (por_req)
        (cause_wr && !any_direct && ext_rst_n && pin_d) |=> (cause_rdata == $past(cause_wdata)));

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (por_req)
        (!sys_rst && !any_direct && ext_rst_n && pin_d) |=> !sys_rst);

    assert_hold_R10: assert property (@(posedge clk) disable iff (por_req)
        (sys_rst && quiet_cnt < LW'(HOLD_LEN - 1)) |=> sys_rst);

    assert_release_R10: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> (quiet_cnt >= LW'(HOLD_LEN)));
endmodule

bind rstc_top rstc_top_chk #(.HOLD_LEN(HOLD_LEN)) u_chk (
    .clk         (clk),
    .por_req     (por_req),
    .bor_req     (bor_req),
    .ext_rst_n   (ext_rst_n),
    .swr_req     (swr_req),
    .wdt_req     (wdt_req),
    .cm_req      (cm_req),
    .trap_req    (trap_req),
    .iop_req     (iop_req),
    .uwr_req     (uwr_req),
    .cause_wr    (cause_wr),
    .cause_wdata (cause_wdata),
    .cause_rdata (cause_rdata),
    .sys_rst     (sys_rst)
);

// File: tb/rstc_top_tb.sv
`timescale 1ns/1ps
module rstc_top_tb;
    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic       bor_req = 1'b0, ext_rst_n = 1'b1, swr_req = 1'b0, wdt_req = 1'b0;
    logic       cm_req = 1'b0, trap_req = 1'b0, iop_req = 1'b0, uwr_req = 1'b0;
    logic       cause_wr = 1'b0;
    logic [7:0] cause_wdata = 8'h00;
    logic [7:0] cause_rdata;
    logic       sys_rst;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int         due;
        int         kind;   // 0: sys_rst, 1: cause_rdata
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    rstc_top u_dut (
        .clk(clk), .por_req(por_req), .bor_req(bor_req), .ext_rst_n(ext_rst_n),
        .swr_req(swr_req), .wdt_req(wdt_req), .cm_req(cm_req), .trap_req(trap_req),
        .iop_req(iop_req), .uwr_req(uwr_req), .cause_wr(cause_wr),
        .cause_wdata(cause_wdata), .cause_rdata(cause_rdata), .sys_rst(sys_rst)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare due items away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = (it.kind == 1) ? cause_rdata : {7'b0, sys_rst};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: cycle %0d actual %0h expected %0h", it.tag, cyc, act, it.exp);
            end
        end
    end

    task automatic expect_at(input int kind, input logic [7:0] v, input int dly, input string tag);
        item_t it;
        it.due = cyc + dly; it.kind = kind; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_src(input int s, input logic v);
        case (s)
            1: bor_req  = v;
            3: swr_req  = v;
            4: wdt_req  = v;
            5: cm_req   = v;
            6: iop_req  = v;
            7: trap_req = v;
            8: uwr_req  = v;
            default: ;
        endcase
    endtask

    // one-cycle pulse on one or two sources, full reset sequence checked
    task automatic pulse(input int s1, input int s2, input logic [7:0] exp_cause, input string tag);
        set_src(s1, 1'b1); set_src(s2, 1'b1);
        expect_at(0, 8'h01, 1, "R1 assert");
        @(negedge clk);
        set_src(s1, 1'b0); set_src(s2, 1'b0);
        expect_at(0, 8'h01, 15, "R10 still held");
        expect_at(0, 8'h00, 16, "R10 released");
        expect_at(1, exp_cause, 16, tag);
        drain();
    endtask

    task automatic write_cause(input logic [7:0] v);
        cause_wr = 1'b1; cause_wdata = v;
        @(negedge clk);
        cause_wr = 1'b0;
        expect_at(1, v, 1, "R8 write value");
        expect_at(0, 8'h00, 1, "R8 write no reset");
        expect_at(0, 8'h00, 3, "R8 write no reset later");
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5 power-on
        expect_at(0, 8'h01, 1, "R5 reset high");
        expect_at(1, 8'h03, 1, "R5 pattern");
        por_req = 1'b0;
        expect_at(0, 8'h01, 15, "R10 por hold");
        expect_at(0, 8'h00, 16, "R10 por release");
        drain();

        write_cause(8'h00);
        pulse(4, 0, 8'h10, "R4 R6 watchdog bit4 kept");
        pulse(3, 5, 8'h38, "R7 R6 swr+cm accumulate");
        write_cause(8'h00);
        pulse(6, 0, 8'h40, "R4 illegal opcode bit6");
        write_cause(8'h00);
        pulse(8, 0, 8'h40, "R4 uninit reg bit6");
        write_cause(8'h00);
        pulse(7, 0, 8'h80, "R4 trap bit7");
        write_cause(8'h00);
        pulse(1, 0, 8'h02, "R4 brown-out bit1");
        write_cause(8'hFF);   // R8 all-ones write, no reset
        write_cause(8'h00);

        // R9 write of zero collides with watchdog set
        cause_wr = 1'b1; cause_wdata = 8'h00; wdt_req = 1'b1;
        @(negedge clk);
        cause_wr = 1'b0; wdt_req = 1'b0;
        expect_at(1, 8'h10, 1, "R9 hw set wins");
        expect_at(0, 8'h00, 16, "R10 release after R9");
        drain();
        write_cause(8'h00);

        // R3 short pin pulse: 3 low edges
        ext_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        expect_at(0, 8'h00, 1, "R3 no reset");
        expect_at(0, 8'h00, 3, "R3 no reset later");
        expect_at(1, 8'h00, 3, "R3 cause untouched");
        drain();

        // R2 pin low for 4 edges
        ext_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_rst_n = 1'b1;
        expect_at(0, 8'h01, 1, "R2 pin reset");
        expect_at(1, 8'h04, 1, "R2 pin cause bit2");
        expect_at(0, 8'h01, 16, "R10 pin hold");
        expect_at(0, 8'h00, 17, "R10 pin release");
        drain();

        // R11 re-trigger during stretch
        write_cause(8'h00);
        wdt_req = 1'b1;
        @(negedge clk);
        wdt_req = 1'b0;
        repeat (6) @(negedge clk);
        swr_req = 1'b1;
        expect_at(0, 8'h01, 1, "R11 still high");
        @(negedge clk);
        swr_req = 1'b0;
        expect_at(0, 8'h01, 15, "R11 hold restarted");
        expect_at(0, 8'h00, 16, "R11 release");
        expect_at(1, 8'h18, 16, "R11 R6 causes");
        drain();

        // R5 power-on again overrides accumulated bits
        por_req = 1'b1;
        repeat (2) @(negedge clk);
        por_req = 1'b0;
        expect_at(1, 8'h03, 1, "R5 reload");
        expect_at(0, 8'h01, 15, "R10 hold after por");
        expect_at(0, 8'h00, 16, "R10 release after por");
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule